// File: doc/BRIEF.md
# Searchable Hazard Queue

This block is the small queue that sits between the decode stage and the execute stage of a simple in-order pipeline. Decode pushes fully decoded instruction templates (operands already read from the register file) into the tail; execute inspects and retires the oldest template from the head. When a taken branch resolves in execute, the whole queue is flushed in one cycle so that the wrongly prefetched templates disappear.

Alongside the queue ports there is a combinational lookup port. Decode presents a register index and learns, in the same cycle, whether any template still waiting in the queue is going to write that register. Decode uses that answer to hold back an instruction that would otherwise read a stale value. Only the arithmetic and load kinds write a register; branch and store templates never produce a hit.

The queue depth is a parameter (default 2). Values are 32 bits wide and register indices 5 bits wide (32 registers), giving a 71-bit template word.

Top module: `hazard_search_fifo`

## Requirements
- R1: After reset the queue is empty: `head_valid_o` is 0, `enq_ready_o` is 1 and `find_hit_o` is 0 for every register index.
- R2: Templates leave in the order they were accepted; while `head_valid_o` is 1, `head_item_o` equals the oldest accepted template, and `deq_i` removes it at the clock edge.
- R3: When the queue holds DEPTH templates and no dequeue happens in the same cycle, `enq_ready_o` is 0 and a push is dropped without changing the contents.
- R4: A dequeue request while the queue is empty is ignored; the queue stays empty.
- R5: On a full queue, a push together with a dequeue in the same cycle is accepted (`enq_ready_o` is 1); the oldest template leaves and the new one joins at the tail.
- R6: `clear_i` empties the queue at the next edge and takes priority: a push or dequeue in the same cycle has no effect.
- R7: Template word layout: kind in bits [70:69] (0 = add, 1 = branch-if-zero, 2 = load, 3 = store). Add: destination [68:64], first operand [63:32], second operand [31:0]. Load: destination [68:64], address [31:0], bits [63:32] zero. Branch: condition [63:32], target [31:0]. Store: data [63:32], address [31:0]. Bits [68:64] are zero for branch and store. The queue returns each word unchanged.
- R8: `find_hit_o` is 1 exactly when some occupied entry is of kind add or load and its bits [68:64] equal `find_reg_i`.
- R9: Branch and store entries never cause a hit, whatever their bits [68:64] hold.
- R10: The lookup sees the entries held at the start of the cycle: a template pushed in the same cycle is not seen until the next cycle, and an entry being dequeued is still seen in its last cycle.
- R11: The number of occupied entries never exceeds DEPTH and always equals the number of entries marked occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Push request |
| enq_item_i | input | 71 | Template to push |
| enq_ready_o | output | 1 | Push will be accepted this cycle |
| deq_i | input | 1 | Remove the oldest template |
| head_valid_o | output | 1 | Queue is not empty |
| head_item_o | output | 71 | Oldest template |
| clear_i | input | 1 | Flush all entries |
| find_reg_i | input | 5 | Register index to look up |
| find_hit_o | output | 1 | A queued template writes that register |

## Verification
The hardest situations to reach are the ones where several controls meet on a boundary: a push and a pop on a full queue, a flush colliding with a push, and a lookup for a register that is being written by a template entering the queue in that very cycle. Directed sequences fill the default two-entry queue and then drive exactly those collisions, including branch and store words whose unused destination bits carry a deliberately matching index. A long run with mostly small register indices then keeps the lookup hitting and missing often while pushes, pops and flushes overlap, all compared with a behavioural queue model every cycle.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  localparam int VAL_W  = 32;
  localparam int NREGS  = 32;
  localparam int REG_W  = $clog2(NREGS);
  localparam int KIND_W = 2;
  localparam int PAY_W  = REG_W + 2 * VAL_W;
  localparam int ITEM_W = KIND_W + PAY_W;

  // field positions inside a template word
  localparam int KIND_LSB = PAY_W;
  localparam int DST_LSB  = 2 * VAL_W;

  typedef enum logic [KIND_W-1:0] {
    K_ADD   = 2'd0,
    K_BZ    = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_e;

  typedef logic [REG_W-1:0]  reg_idx_t;
  typedef logic [ITEM_W-1:0] item_t;

  function automatic kind_e item_kind(item_t w);
    return kind_e'(w[KIND_LSB +: KIND_W]);
  endfunction

  function automatic reg_idx_t item_dst(item_t w);
    return w[DST_LSB +: REG_W];
  endfunction

  function automatic logic kind_writes_reg(kind_e k);
    return (k == K_ADD) || (k == K_LOAD);
  endfunction
endpackage

// File: rtl/hsf_ctrl.sv
module hsf_ctrl #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic             deq_i,
  input  logic             clear_i,
  output logic             enq_ready_o,
  output logic             not_empty_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, empty;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  assign pop_o       = deq_i & ~empty & ~clear_i;
  assign enq_ready_o = ~full | (deq_i & ~empty);
  // clear wins over a push in the same cycle
  assign push_o      = enq_valid_i & enq_ready_o & ~clear_i;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_o) wr_q <= bump(wr_q);
      if (pop_o)  rd_q <= bump(rd_q);
      case ({push_o, pop_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign not_empty_o = ~empty;
  assign wr_ptr_o    = wr_q;
  assign rd_ptr_o    = rd_q;
  assign count_o     = cnt_q;
endmodule

// File: rtl/hsf_store.sv
module hsf_store
  import hsf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic                  pop_i,
  input  logic                  clear_i,
  input  logic [PTR_W-1:0]      wr_ptr_i,
  input  logic [PTR_W-1:0]      rd_ptr_i,
  input  item_t                 wr_item_i,
  output item_t                 head_o,
  output logic [DEPTH-1:0]      occ_o,
  output kind_e [DEPTH-1:0]     kind_o,
  output reg_idx_t [DEPTH-1:0]  dst_o
);
  item_t            mem_q [DEPTH];
  logic [DEPTH-1:0] occ_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (push_i && !clear_i && wr_ptr_i == IDX) begin
        mem_q[i] <= wr_item_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[i] <= 1'b0;
      end else if (clear_i) begin
        occ_q[i] <= 1'b0;
      end else if (push_i && wr_ptr_i == IDX) begin
        occ_q[i] <= 1'b1;
      end else if (pop_i && rd_ptr_i == IDX) begin
        occ_q[i] <= 1'b0;
      end
    end

    assign kind_o[i] = item_kind(mem_q[i]);
    assign dst_o[i]  = item_dst(mem_q[i]);
  end

  assign head_o = mem_q[rd_ptr_i];
  assign occ_o  = occ_q;
endmodule

// File: rtl/hsf_match.sv
module hsf_match
  import hsf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic [DEPTH-1:0]     occ_i,
  input  kind_e [DEPTH-1:0]    kind_i,
  input  reg_idx_t [DEPTH-1:0] dst_i,
  input  reg_idx_t             key_i,
  output logic                 hit_o
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign slot_hit[i] = occ_i[i] & kind_writes_reg(kind_i[i]) & (dst_i[i] == key_i);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/hazard_search_fifo.sv
module hazard_search_fifo
  import hsf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [ITEM_W-1:0] enq_item_i,
  output logic              enq_ready_o,
  input  logic              deq_i,
  output logic              head_valid_o,
  output logic [ITEM_W-1:0] head_item_o,
  input  logic              clear_i,
  input  logic [REG_W-1:0]  find_reg_i,
  output logic              find_hit_o
);
  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] occ_q;
  kind_e [DEPTH-1:0]    slot_kind;
  reg_idx_t [DEPTH-1:0] slot_dst;

  hsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_valid_i (enq_valid_i),
    .deq_i       (deq_i),
    .clear_i     (clear_i),
    .enq_ready_o (enq_ready_o),
    .not_empty_o (head_valid_o),
    .push_o      (push),
    .pop_o       (pop),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count_q)
  );

  hsf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .pop_i     (pop),
    .clear_i   (clear_i),
    .wr_ptr_i  (wr_ptr),
    .rd_ptr_i  (rd_ptr),
    .wr_item_i (enq_item_i),
    .head_o    (head_item_o),
    .occ_o     (occ_q),
    .kind_o    (slot_kind),
    .dst_o     (slot_dst)
  );

  hsf_match #(.DEPTH(DEPTH)) u_match (
    .occ_i  (occ_q),
    .kind_i (slot_kind),
    .dst_i  (slot_dst),
    .key_i  (find_reg_i),
    .hit_o  (find_hit_o)
  );
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker
  import hsf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enq_valid_i,
  input logic              deq_i,
  input logic              clear_i,
  input logic              head_valid_o,
  input logic [ITEM_W-1:0] head_item_o,
  input logic              find_hit_o,
  input logic [CNT_W-1:0]  count_q,
  input logic [DEPTH-1:0]  occ_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  assert_empty_no_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_o |-> !find_hit_o);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);

  assert_occupancy_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ_q) == int'(count_q));

  assert_full_blocks_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == FULL_CNT && enq_valid_i && !deq_i && !clear_i)
      |=> (count_q == FULL_CNT) && $stable(head_item_o));

  assert_empty_pop_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!head_valid_o && deq_i && !enq_valid_i && !clear_i) |=> !head_valid_o);

  assert_swap_on_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == FULL_CNT && enq_valid_i && deq_i && !clear_i) |=> count_q == FULL_CNT);

  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!head_valid_o && !find_hit_o));

  assert_no_write_kind_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == ONE_CNT &&
     (head_item_o[ITEM_W-1 -: KIND_W] == K_BZ || head_item_o[ITEM_W-1 -: KIND_W] == K_STORE))
      |-> !find_hit_o);
endmodule

bind hazard_search_fifo hsf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enq_valid_i  (enq_valid_i),
  .deq_i        (deq_i),
  .clear_i      (clear_i),
  .head_valid_o (head_valid_o),
  .head_item_o  (head_item_o),
  .find_hit_o   (find_hit_o),
  .count_q      (count_q),
  .occ_q        (occ_q)
);

// File: tb/tb_hazard_search_fifo.sv
module tb_hazard_search_fifo;
  localparam int DEPTH = 2;
  localparam int W     = 71;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enq_valid_i = 1'b0;
  logic [W-1:0] enq_item_i = '0;
  logic enq_ready_o;
  logic deq_i = 1'b0;
  logic head_valid_o;
  logic [W-1:0] head_item_o;
  logic clear_i = 1'b0;
  logic [4:0] find_reg_i = '0;
  logic find_hit_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [W-1:0] model_q[$];

  always #10 clk_i = ~clk_i;

  hazard_search_fifo #(.DEPTH(DEPTH)) dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] mk(int kind, int dst, logic [31:0] a, logic [31:0] b);
    return {2'(kind), 5'(dst), a, b};
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational outputs to model, clock, update model
  task automatic step(string tag, logic ev, logic [W-1:0] item, logic dq, logic clr, int key);
    logic exp_hit, exp_rdy, do_pop, do_push;
    enq_valid_i = ev; enq_item_i = item; deq_i = dq; clear_i = clr; find_reg_i = 5'(key);
    #1;
    exp_hit = 1'b0;
    foreach (model_q[i])
      if ((model_q[i][70:69] == 2'd0 || model_q[i][70:69] == 2'd2) && model_q[i][68:64] == 5'(key))
        exp_hit = 1'b1;
    exp_rdy = (model_q.size() < DEPTH) || (dq && model_q.size() > 0);
    chk(tag, "head_valid", W'(head_valid_o), W'(model_q.size() > 0));
    if (model_q.size() > 0) chk(tag, "head_item", head_item_o, model_q[0]);
    chk(tag, "find_hit", W'(find_hit_o), W'(exp_hit));
    chk(tag, "enq_ready", W'(enq_ready_o), W'(exp_rdy));
    @(posedge clk_i);
    if (clr) model_q.delete();
    else begin
      do_pop  = dq && model_q.size() > 0;
      do_push = ev && exp_rdy;
      if (do_pop) void'(model_q.pop_front());
      if (do_push) model_q.push_back(item);
    end
    @(negedge clk_i);
    enq_valid_i = 0; deq_i = 0; clear_i = 0;
  endtask

  initial begin
    logic [W-1:0] a1, a2, l1, bz, st;
    a1 = mk(0, 3, 32'h1111_0001, 32'h2222_0002);
    a2 = mk(0, 7, 32'hdead_beef, 32'h0000_0005);
    l1 = mk(2, 9, 32'h0, 32'h0000_0400);
    bz = mk(1, 4, 32'h0, 32'h0000_0080);   // R9: garbage dst bits
    st = mk(3, 5, 32'hcafe_0000, 32'h0000_0100);
    #35;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "head_valid after reset", W'(head_valid_o), '0);
    chk("R1", "enq_ready after reset", W'(enq_ready_o), W'(1));
    for (int r = 0; r < 32; r++) begin
      find_reg_i = 5'(r); #1;
      chk("R1", "find_hit after reset", W'(find_hit_o), '0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R4", 0, '0, 1, 0, 0);            // pop on empty ignored
    step("R10", 1, a1, 0, 0, 3);           // same-cycle push not seen
    step("R8", 0, '0, 0, 0, 3);            // now seen
    step("R7", 1, l1, 0, 0, 9);
    step("R3", 1, a2, 0, 0, 9);            // full: dropped
    step("R3", 0, '0, 0, 0, 7);            // a2 must not be present
    step("R5", 1, a2, 1, 0, 3);            // swap on full; popped entry still seen
    step("R2", 0, '0, 1, 0, 7);
    step("R2", 0, '0, 1, 0, 7);
    step("R9", 1, bz, 0, 0, 4);
    step("R9", 1, st, 0, 0, 5);
    step("R9", 0, '0, 0, 0, 4);
    step("R9", 0, '0, 0, 0, 5);
    step("R6", 1, a1, 1, 1, 3);            // clear wins over push and pop
    step("R6", 0, '0, 0, 0, 3);
    step("R11", 1, a1, 0, 0, 3);
    step("R11", 1, a2, 0, 0, 7);
    step("R11", 1, l1, 0, 0, 9);
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] it;
      it = {2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 32'($urandom), 32'($urandom)};
      step("R2/R8 random", 1'($urandom_range(0, 1)), it, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 15) == 0), $urandom_range(0, 3));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule